// File: doc/BRIEF.md
# Buffered Host Write Port

This block is the host-facing slave port of a peripheral. A CPU drives select and strobe lines that have no timing relation to the peripheral clock. The port synchronizes these lines and waits until an internal engine has released the RAM. It then starts a transfer by pulling its enable output low. It captures the access type, address and data, and issues one write on an internal write port, aimed at either the RAM or the register file. It signals completion by pulling its ready output low.

The access type (memory or register, read or write) is captured on the first falling clock edge after the enable goes low. Address and data are captured on the following rising edge. A strobe that arrives late in a clock period delays the address/data capture by one clock, and ready moves back by the same clock. Enable and ready stay low until the strobe is seen high again. A strobe that is held low therefore cannot start a second transfer.

Top module: `host_wr_port`

## Requirements
- R1: The select and strobe inputs pass through a two-flop synchronizer. If both go low early in a clock period (before the falling edge), `ioen_n` goes low on the third rising edge after they fall.
- R2: While `busy` is high, `ioen_n` stays high. Once `busy` drops with a request already synchronized, `ioen_n` goes low on the next rising edge.
- R3: After `ioen_n` is low, `sel_n` is ignored. Raising it does not stop or change the transfer.
- R4: `mem_sel` and `rdwr` are captured on the first falling clock edge after `ioen_n` goes low. Changes before that edge are taken and later changes are ignored. A captured `mem_sel` of 1 routes the write to `wr_mem`, and 0 routes it to `wr_reg`.
- R5: In a normal transfer, `addr` and `data` are captured on the first rising edge after `ioen_n` goes low. Later changes are ignored.
- R6: With `wr_pol`=1, `rdwr`=0 denotes a write. With `wr_pol`=0, `rdwr`=1 denotes a write. A read cycle completes the handshake without any write pulse.
- R7: `ready_n` goes low two clocks after the address/data capture edge, which is three clocks after `ioen_n` falls in a normal transfer. In that same cycle `wr_en` is high for exactly one clock, carrying the captured address and data.
- R8: A request that first reaches the synchronizer after the preceding falling edge is a late request. For a late request, the address/data capture moves one rising edge later, and the `ioen_n`-to-`ready_n` delay becomes four clocks.
- R9: `ioen_n` and `ready_n` stay low while `strb_n` is low. After `strb_n` goes high they both return high on the third rising edge. A held strobe produces no second write.
- R10: Asynchronous reset drives `ioen_n` and `ready_n` high and `wr_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Host select, active low, asynchronous |
| strb_n | input | 1 | Host strobe, active low, asynchronous |
| mem_sel | input | 1 | 1 = memory access, 0 = register access |
| rdwr | input | 1 | Read/write direction, sense set by `wr_pol` |
| wr_pol | input | 1 | Direction polarity strap |
| addr | input | AW | Host address |
| data | input | DW | Host write data |
| busy | input | 1 | Internal engine owns the RAM |
| ioen_n | output | 1 | Transfer in progress, active low |
| ready_n | output | 1 | Transfer complete, active low |
| wr_en | output | 1 | One-clock internal write strobe |
| wr_mem | output | 1 | Write targets RAM |
| wr_reg | output | 1 | Write targets register file |
| wr_addr | output | AW | Captured address |
| wr_data | output | DW | Captured data |

## Verification
A wrong synchronizer depth or a wrong late-request flag shows at the ports within a handful of clocks. It appears as `ioen_n` falling on the wrong edge, or as a wrong enable-to-ready distance. The bench counts both distances exactly.

Inputs are changed on each side of the falling and rising capture edges. A capture taken on the wrong edge therefore shows at the very next write as a wrong target, address or data. A release decoder that misreads the strobe shows as enable staying low, or rising too early, around the third edge after the strobe rises.

// File: rtl/host_wr_port.sv
`timescale 1ns/1ps
module host_wr_port #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int READY_GAP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          strb_n,
  input  logic          mem_sel,
  input  logic          rdwr,
  input  logic          wr_pol,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          busy,
  output logic          ioen_n,
  output logic          ready_n,
  output logic          wr_en,
  output logic          wr_mem,
  output logic          wr_reg,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int CW = $clog2(READY_GAP + 2) + 1;
  localparam logic [CW-1:0] GAP = CW'(READY_GAP);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_HOLD} st_t;
  st_t st;

  logic req, half, rq1, rq2, ea1, ea2, sb1, sb2;
  logic late_q, ctl_hit, mem_q, rdwr_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lat_at;
  logic is_wr;

  assign req    = ~sel_n & ~strb_n;
  assign lat_at = {{(CW-1){1'b0}}, late_q};
  assign is_wr  = wr_pol ? ~rdwr_q : rdwr_q;
  assign wr_mem = wr_en & mem_q;
  assign wr_reg = wr_en & ~mem_q;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) half <= 1'b0;
    else        half <= req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rq1 <= 1'b0; rq2 <= 1'b0;
      ea1 <= 1'b0; ea2 <= 1'b0;
      sb1 <= 1'b1; sb2 <= 1'b1;
    end else begin
      rq1 <= req;  rq2 <= rq1;
      ea1 <= half; ea2 <= ea1;
      sb1 <= strb_n; sb2 <= sb1;
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_hit <= 1'b0;
      mem_q   <= 1'b0;
      rdwr_q  <= 1'b0;
    end else if (ioen_n) begin
      ctl_hit <= 1'b0;
    end else if (!ctl_hit) begin
      ctl_hit <= 1'b1;
      mem_q   <= mem_sel;
      rdwr_q  <= rdwr;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      ioen_n  <= 1'b1;
      ready_n <= 1'b1;
      wr_en   <= 1'b0;
      late_q  <= 1'b0;
      cnt     <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (rq2 && !busy) begin
            ioen_n <= 1'b0;
            late_q <= ~ea2;
            cnt    <= '0;
            st     <= S_XFER;
          end
        S_XFER: begin
          cnt <= cnt + 1'b1;
          if (cnt == lat_at) begin
            wr_addr <= addr;
            wr_data <= data;
          end
          if (cnt == lat_at + GAP) begin
            ready_n <= 1'b0;
            wr_en   <= is_wr;
            st      <= S_HOLD;
          end
        end
        S_HOLD: begin
          wr_en <= 1'b0;
          if (sb2) begin
            ioen_n  <= 1'b1;
            ready_n <= 1'b1;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
endmodule

module host_wr_port_chk (
  input logic clk,
  input logic rst_n,
  input logic strb_n,
  input logic busy,
  input logic ioen_n,
  input logic ready_n,
  input logic wr_en
);
  // R7
  ready_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n |-> !ioen_n);
  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R7
  pulse_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $fell(ready_n));
  // R2
  busy_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ioen_n) |=> ioen_n);
  // R9
  release_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ioen_n) |-> ($past(strb_n, 3) && $rose(ready_n)));
endmodule

bind host_wr_port host_wr_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strb_n(strb_n), .busy(busy),
  .ioen_n(ioen_n), .ready_n(ready_n), .wr_en(wr_en)
);

// File: tb/test_host_wr_port.sv
`timescale 1ns/1ps
module test_host_wr_port;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sel_n, strb_n, mem_sel, rdwr, wr_pol, busy;
  logic [15:0] addr, data;
  logic ioen_n, ready_n, wr_en, wr_mem, wr_reg;
  logic [15:0] wr_addr, wr_data;

  host_wr_port i_host_wr_port (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strb_n(strb_n),
    .mem_sel(mem_sel), .rdwr(rdwr), .wr_pol(wr_pol), .addr(addr),
    .data(data), .busy(busy), .ioen_n(ioen_n), .ready_n(ready_n),
    .wr_en(wr_en), .wr_mem(wr_mem), .wr_reg(wr_reg),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // {tweak, late, mem, rdwr, pol, addr, data}
  localparam int NV = 8;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h1234, 16'hABCD},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0005, 16'h5A5A},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0777, 16'h1111},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0001},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h00A0, 16'h8000},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h4400, 16'h2222},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h9001, 16'h7E7E},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0101, 16'h3333}
  };

  task automatic run_xfer(input logic tw, input logic lt, input logic m, input logic rw,
                          input logic p, input logic [15:0] a, input logic [15:0] d);
    int n;
    int wrs;
    logic exp_w, exp_m;
    logic [15:0] ea, ed;
    exp_w = p ? ~rw : rw;
    exp_m = tw ? ~m : m;
    ea = tw ? (lt ? a ^ 16'h3C3C : a ^ 16'h00FF) : a;
    ed = tw ? (lt ? d ^ 16'hC3C3 : d ^ 16'h0F0F) : d;
    @(posedge clk);
    if (lt) #4; else #0.5;
    mem_sel = m; rdwr = rw; wr_pol = p; addr = a; data = d;
    sel_n = 1'b0; strb_n = 1'b0;
    n = 0;
    do begin tick(); n++; end while (ioen_n && n < 10);
    chk("R1", n, 3, "edges to enable");
    if (tw) begin
      mem_sel = ~m; addr = a ^ 16'h00FF; data = d ^ 16'h0F0F; sel_n = 1'b1;
      #2;
      mem_sel = m;
    end
    n = 0;
    do begin
      tick(); n++;
      if (tw && n == 1) begin addr = a ^ 16'h3C3C; data = d ^ 16'hC3C3; end
    end while (ready_n && n < 10);
    if (lt) chk("R8", n, 4, "late enable-to-ready clocks");
    else    chk("R7", n, 3, "enable-to-ready clocks");
    if (tw) chk("R3", ready_n, 0, "ready after select dropped");
    chk("R6", wr_en, exp_w, "write pulse vs polarity");
    if (exp_w) begin
      chk("R4", {wr_mem, wr_reg}, {exp_m, ~exp_m}, "target mem/reg");
      if (lt) chk("R8", wr_addr, ea, "late address capture");
      else    chk("R5", wr_addr, ea, "address capture");
      chk("R5", wr_data, ed, "data capture");
    end
    wrs = 0;
    repeat (4) begin tick(); if (wr_en) wrs++; end
    chk("R9", wrs, 0, "no extra pulse on held strobe");
    chk("R9", {ioen_n, ready_n}, 2'b00, "held low with strobe low");
    strb_n = 1'b1; sel_n = 1'b1;
    tick(); tick();
    chk("R9", ioen_n, 0, "still low two edges after strobe rise");
    tick();
    chk("R9", {ioen_n, ready_n}, 2'b11, "released third edge");
    tick(); tick();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    int n;
    rst_n = 1'b0; sel_n = 1'b1; strb_n = 1'b1; mem_sel = 1'b0; rdwr = 1'b1;
    wr_pol = 1'b1; busy = 1'b0; addr = '0; data = '0;
    repeat (3) tick();
    chk("R10", {ioen_n, ready_n, wr_en}, 3'b110, "reset state");
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      v = VEC[i];
      run_xfer(v[36], v[35], v[34], v[33], v[32], v[31:16], v[15:0]);
    end

    // R2: busy hold-off
    busy = 1'b1;
    @(posedge clk); #0.5;
    mem_sel = 1'b1; rdwr = 1'b0; wr_pol = 1'b1; addr = 16'h0BEE; data = 16'h00EE;
    sel_n = 1'b0; strb_n = 1'b0;
    ok = 1'b1;
    repeat (8) begin tick(); if (!ioen_n) ok = 1'b0; end
    chk("R2", ok, 1, "enable held high while busy");
    busy = 1'b0;
    tick();
    chk("R2", ioen_n, 0, "enable one edge after busy drops");
    n = 0;
    do begin tick(); n++; end while (ready_n && n < 10);
    chk("R7", {wr_en, wr_mem, wr_addr}, {1'b1, 1'b1, 16'h0BEE}, "write after hold-off");
    strb_n = 1'b1; sel_n = 1'b1;
    repeat (3) tick();
    chk("R9", ioen_n, 1, "release after hold-off");

    // R10: reset mid-transfer
    @(posedge clk); #0.5;
    sel_n = 1'b0; strb_n = 1'b0;
    n = 0;
    do begin tick(); n++; end while (ioen_n && n < 10);
    rst_n = 1'b0;
    #0.5;
    chk("R10", {ioen_n, ready_n, wr_en}, 3'b110, "reset during transfer");
    strb_n = 1'b1; sel_n = 1'b1;
    tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R10", {ioen_n, ready_n, wr_en}, 3'b110, "idle after reset");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule